// File: doc/BRIEF.md
# Three-Phase Bridge Fault Diagnostic Logic

This block turns the digitized outputs of a three-phase gate driver's analog fault comparators into its diagnostic pins and protective requests. Each comparator input first passes through a reset-cleared synchronizer. The outputs are then formed combinationally from the synchronized conditions, the enable input and the gate commands currently issued by the gate logic. Nothing is latched, so every fault clears as soon as its source clears.

Drain-source faults count only on a gate that is actually commanded on. A high-side trip is a short to ground, and a low-side trip is a short to battery. A collapsed drain reference (bridge open) shows up as a short to ground on every phase. None of these faults is detected while enable is low. One active-low summary line collects every fault. Two battery flags report overvoltage and undervoltage, and both stop driving when the chip is in thermal shutdown or logic-supply undervoltage. Only thermal shutdown, logic-supply undervoltage and battery undervoltage lead to protective action: gates forced low, boost converter off and gate-supply regulator off.

Top module: `bridge_fault_diag`

## Requirements
- R1: While reset is held and right after it is released, all outputs are idle: `fault_n_o`=1, both flags 0 with both output enables 1, all three off requests 0, `stg_o` and `stb_o` all zero.
- R2: A change on any comparator input (`ds_hi_trip_i`, `ds_lo_trip_i`, `drain_open_i`, `bat_ov_i`, `bat_uv_i`, `gsup_uv_i`, `lsup_uv_i`, `therm_i`) reaches the outputs after exactly SYNC_STAGES rising clock edges (default 2). `en_i`, `hi_cmd_i` and `lo_cmd_i` act within the same cycle.
- R3: Bit p of `stb_o` (short to battery, phase p at bit p) is 1 exactly when `en_i`=1, `lo_cmd_i[p]`=1 and the synchronized `ds_lo_trip_i[p]`=1.
- R4: Bit p of `stg_o` (short to ground) is 1 exactly when `en_i`=1 and either `hi_cmd_i[p]` and the synchronized `ds_hi_trip_i[p]` are both 1, or the synchronized `drain_open_i` is 1. A bridge-open condition sets every bit of `stg_o`, whatever the gate commands are.
- R5: With `en_i`=0, `stg_o` and `stb_o` stay zero and drain-source or bridge-open inputs do not pull `fault_n_o` low.
- R6: `fault_n_o` is 0 exactly when at least one of these is present: battery overvoltage, battery undervoltage, gate-supply undervoltage, logic-supply undervoltage, thermal shutdown, or any bit of `stg_o` or `stb_o`.
- R7: `ov_oe_o` and `uv_oe_o` are both 0 (flags high-impedance) exactly when thermal shutdown or logic-supply undervoltage is present. Otherwise both are 1.
- R8: While driven, `uv_flag_o` equals the battery undervoltage condition and `ov_flag_o` equals the battery overvoltage condition, except that undervoltage wins when both are present. The two flags are never 1 together, and both read 0 while their enables are 0.
- R9: `gate_off_o`, `boost_off_o` and `reg_off_o` are equal. They are 1 exactly when thermal shutdown, logic-supply undervoltage or battery undervoltage is present. Drain-source, bridge-open, overvoltage and gate-supply faults never raise them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bridge enable |
| hi_cmd_i | input | PHASES | High-side gate commands, bit p = phase p |
| lo_cmd_i | input | PHASES | Low-side gate commands |
| ds_hi_trip_i | input | PHASES | High-side drain-source comparator trips |
| ds_lo_trip_i | input | PHASES | Low-side drain-source comparator trips |
| drain_open_i | input | 1 | Drain reference below bridge-open threshold |
| bat_ov_i | input | 1 | Battery overvoltage comparator |
| bat_uv_i | input | 1 | Battery undervoltage comparator |
| gsup_uv_i | input | 1 | Gate-supply undervoltage comparator |
| lsup_uv_i | input | 1 | Logic-supply undervoltage comparator |
| therm_i | input | 1 | Thermal shutdown comparator |
| fault_n_o | output | 1 | Summary fault, active low |
| ov_flag_o | output | 1 | Overvoltage flag value |
| ov_oe_o | output | 1 | Overvoltage flag drive enable |
| uv_flag_o | output | 1 | Undervoltage flag value |
| uv_oe_o | output | 1 | Undervoltage flag drive enable |
| gate_off_o | output | 1 | Force all gates low |
| boost_off_o | output | 1 | Turn boost converter off |
| reg_off_o | output | 1 | Turn gate-supply regulator off |
| stg_o | output | PHASES | Short-to-ground per phase |
| stb_o | output | PHASES | Short-to-battery per phase |

## Verification
The phase qualification is swept over every combination of enable, the six gate commands, the six drain-source trips and bridge-open. This separates a trip on a commanded gate from one on an idle gate, a high-side trip from a low-side one, and bridge-open from a real short to ground. It also shows that enable masks all of them. A second sweep runs through all 32 combinations of the five supply and thermal conditions, with enable both low and high and with the phases both quiet and faulted. This exposes the tri-state encoding, the undervoltage-over-overvoltage priority and the split between conditions that only report and those that also shut down. A dedicated step times the synchronizer latency edge by edge and checks that enable acts in the same cycle.

// File: rtl/bridge_fault_diag.sv
module bridge_fault_diag #(
  parameter int PHASES      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PHASES-1:0] hi_cmd_i,
  input  logic [PHASES-1:0] lo_cmd_i,
  input  logic [PHASES-1:0] ds_hi_trip_i,
  input  logic [PHASES-1:0] ds_lo_trip_i,
  input  logic              drain_open_i,
  input  logic              bat_ov_i,
  input  logic              bat_uv_i,
  input  logic              gsup_uv_i,
  input  logic              lsup_uv_i,
  input  logic              therm_i,
  output logic              fault_n_o,
  output logic              ov_flag_o,
  output logic              ov_oe_o,
  output logic              uv_flag_o,
  output logic              uv_oe_o,
  output logic              gate_off_o,
  output logic              boost_off_o,
  output logic              reg_off_o,
  output logic [PHASES-1:0] stg_o,
  output logic [PHASES-1:0] stb_o
);

  localparam int RAW_W = 2*PHASES + 6;

  logic [RAW_W-1:0] raw;
  logic [RAW_W-1:0] sq [SYNC_STAGES];

  logic [PHASES-1:0] ds_hi_s, ds_lo_s;
  logic open_s, ov_s, uv_s, gsup_s, lsup_s, therm_s;
  logic hiz, shut;

  assign raw = {ds_hi_trip_i, ds_lo_trip_i, drain_open_i,
                bat_ov_i, bat_uv_i, gsup_uv_i, lsup_uv_i, therm_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sq[i] <= '0;
    end else begin
      sq[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
    end
  end

  assign {ds_hi_s, ds_lo_s, open_s, ov_s, uv_s, gsup_s, lsup_s, therm_s} =
         sq[SYNC_STAGES-1];

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign stb_o[p] = en_i & lo_cmd_i[p] & ds_lo_s[p];
    assign stg_o[p] = en_i & ((hi_cmd_i[p] & ds_hi_s[p]) | open_s);
  end

  assign hiz  = therm_s | lsup_s;
  assign shut = hiz | uv_s;

  assign fault_n_o = ~(ov_s | uv_s | gsup_s | hiz | (|stg_o) | (|stb_o));

  assign ov_oe_o   = ~hiz;
  assign uv_oe_o   = ~hiz;
  assign uv_flag_o = uv_s & ~hiz;
  assign ov_flag_o = ov_s & ~uv_s & ~hiz;

  assign gate_off_o  = shut;
  assign boost_off_o = shut;
  assign reg_off_o   = shut;

endmodule

// File: rtl/bridge_fault_diag_chk.sv
module bridge_fault_diag_chk #(
  parameter int PHASES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [PHASES-1:0] hi_cmd_i,
  input logic [PHASES-1:0] lo_cmd_i,
  input logic              fault_n_o,
  input logic              ov_flag_o,
  input logic              ov_oe_o,
  input logic              uv_flag_o,
  input logic              uv_oe_o,
  input logic              gate_off_o,
  input logic              boost_off_o,
  input logic              reg_off_o,
  input logic [PHASES-1:0] stg_o,
  input logic [PHASES-1:0] stb_o
);

  a_r3_stb_needs_low_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o & ~lo_cmd_i) == '0);

  a_r4_open_hits_all: assert property (@(posedge clk) disable iff (!rst_n)
    ((stg_o & ~hi_cmd_i) != '0) |-> (stg_o == '1));

  a_r5_enable_masks: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (stg_o == '0 && stb_o == '0));

  a_r6_phase_fault_summary: assert property (@(posedge clk) disable iff (!rst_n)
    ((stg_o | stb_o) != '0) |-> !fault_n_o);

  a_r7_oe_together: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_oe_o == uv_oe_o) && (!ov_oe_o -> gate_off_o));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ov_flag_o && uv_flag_o));

  a_r8_flags_quiet_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_oe_o |-> (!ov_flag_o && !uv_flag_o));

  a_r9_off_group: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off_o == boost_off_o) && (gate_off_o == reg_off_o) &&
    (gate_off_o -> !fault_n_o));

endmodule

bind bridge_fault_diag bridge_fault_diag_chk #(.PHASES(PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .hi_cmd_i(hi_cmd_i), .lo_cmd_i(lo_cmd_i),
  .fault_n_o(fault_n_o), .ov_flag_o(ov_flag_o), .ov_oe_o(ov_oe_o),
  .uv_flag_o(uv_flag_o), .uv_oe_o(uv_oe_o), .gate_off_o(gate_off_o),
  .boost_off_o(boost_off_o), .reg_off_o(reg_off_o), .stg_o(stg_o), .stb_o(stb_o)
);

// File: tb/bridge_fault_diag_bench.sv
module bridge_fault_diag_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] hi = '0, lo = '0, dshi = '0, dslo = '0;
  logic dopen = 1'b0, ov = 1'b0, uv = 1'b0, gsup = 1'b0, lsup = 1'b0, therm = 1'b0;

  logic fault_n, ov_f, ov_oe, uv_f, uv_oe, goff, boff, roff;
  logic [2:0] stg, stb;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_fault_diag #(.PHASES(3), .SYNC_STAGES(SYNC)) u_bridge_fault_diag (
    .clk(clk), .rst_n(rst_n), .en_i(en), .hi_cmd_i(hi), .lo_cmd_i(lo),
    .ds_hi_trip_i(dshi), .ds_lo_trip_i(dslo), .drain_open_i(dopen),
    .bat_ov_i(ov), .bat_uv_i(uv), .gsup_uv_i(gsup), .lsup_uv_i(lsup), .therm_i(therm),
    .fault_n_o(fault_n), .ov_flag_o(ov_f), .ov_oe_o(ov_oe), .uv_flag_o(uv_f),
    .uv_oe_o(uv_oe), .gate_off_o(goff), .boost_off_o(boff), .reg_off_o(roff),
    .stg_o(stg), .stb_o(stb)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [2:0] e_stb, e_stg;
    logic e_any, e_hiz, e_shut;
    e_stb  = en ? (lo & dslo) : 3'b000;
    e_stg  = en ? ((hi & dshi) | {3{dopen}}) : 3'b000;
    e_hiz  = therm | lsup;
    e_shut = e_hiz | uv;
    e_any  = ov | uv | gsup | e_hiz | (|e_stg) | (|e_stb);
    chk({5'b0, stb}, {5'b0, e_stb}, "R3 stb");
    chk({5'b0, stg}, {5'b0, e_stg}, "R4/R5 stg");
    chk({7'b0, fault_n}, {7'b0, ~e_any}, "R6/R5 fault_n");
    chk({6'b0, ov_oe, uv_oe}, {6'b0, ~e_hiz, ~e_hiz}, "R7 oe");
    chk({6'b0, ov_f, uv_f}, {6'b0, ov & ~uv & ~e_hiz, uv & ~e_hiz}, "R8 flags");
    chk({5'b0, goff, boff, roff}, {5'b0, {3{e_shut}}}, "R9 off requests");
  endtask

  initial begin
    int unsigned cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<200000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dshi = 3'b111; dslo = 3'b111; uv = 1'b1; therm = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state holds even with faults present at the inputs
    chk({fault_n, ov_oe, uv_oe, ov_f, uv_f, goff, boff, roff}, 8'b1110_0000, "R1 reset idle");
    chk({2'b0, stg, stb}, 8'h00, "R1 reset phases");
    dshi = '0; dslo = '0; uv = 1'b0; therm = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk({fault_n, ov_oe, uv_oe, ov_f, uv_f, goff, boff, roff}, 8'b1110_0000, "R1 after release");

    // R2: latency of the synchronizer, counted edge by edge
    therm = 1'b1;
    @(posedge clk); @(negedge clk);
    chk({7'b0, goff}, 8'h00, "R2 not after one edge");
    @(posedge clk); @(negedge clk);
    chk({7'b0, goff}, 8'h01, "R2 after two edges");
    therm = 1'b0;
    settle();
    chk({7'b0, goff}, 8'h00, "R2 clears with source");
    // R2: enable and commands act in the same cycle
    lo = 3'b010; dslo = 3'b010;
    settle();
    chk({5'b0, stb}, 8'h00, "R2 masked before enable");
    en = 1'b1;
    #1;
    chk({5'b0, stb}, 8'h02, "R2 enable same cycle");
    lo = 3'b000;
    #1;
    chk({5'b0, stb}, 8'h00, "R2 command same cycle");

    // R3 R4 R5 R6: exhaustive phase sweep
    for (int v = 0; v < 16384; v++) begin
      @(negedge clk);
      en = v[0]; hi = v[3:1]; lo = v[6:4]; dshi = v[9:7]; dslo = v[12:10]; dopen = v[13];
      settle();
      check_all();
    end

    // R6 R7 R8 R9: all supply/thermal combinations, quiet and faulted phases
    for (int s = 0; s < 128; s++) begin
      @(negedge clk);
      {therm, lsup, gsup, uv, ov} = s[4:0];
      en = s[5];
      hi = s[6] ? 3'b001 : 3'b000; dshi = 3'b001;
      lo = 3'b000; dslo = 3'b000; dopen = 1'b0;
      settle();
      check_all();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule